// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block decides which interrupt request a small processor core should service next. Each source is one of two kinds, chosen per bit by a parameter mask. An event source latches a sticky pending flag. A level source has no flag and requests service only while its input is high. A pending request needs its own enable bit and a global enable before it can be taken. Among the qualifying requests, the lowest source index wins.

The core reports each instruction boundary on `retire_i`. At such a boundary the block may raise `take_o` for one cycle, with the index of the winning source on `vec_o`. In that same cycle it drops the global enable and clears the chosen event flag. The core signals a return from a handler and explicit set or clear of the global enable on dedicated pins. Software reads the event flags on `flags_o` and clears them by writing ones on the clear port.

The accept handshake is a plain strobe and not a valid/ready pair. The core never stalls an accept: it has to act on `take_o` in the cycle it is asserted. There is no back-pressure.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `flags_o` is all zeros, `gie_o` is 0, `take_o` is 0, and all per-source enables are 0.
- R2: For an event source (bit i of `LVL_MASK` is 0), a high `src_i[i]` in a cycle sets `flags_o[i]` at the next edge. This happens whatever the state of the per-source enable and the global enable.
- R3: When `clr_we_i` is high, every event flag whose bit in `clr_data_i` is 1 is cleared at the next edge. Zero bits leave their flag unchanged. A new event on the same bit in that cycle wins, and the flag stays set.
- R4: A level source (bit i of `LVL_MASK` is 1) never shows a flag. It requests service only in the cycles where `src_i[i]` is high. A pulse that ends while the source cannot be taken leaves no trace.
- R5: `take_o` is high in a cycle only if all of the following hold: `retire_i` is 1, `gie_o` is 1, `cli_i` is 0, `reti_i` is 0, and at least one enabled request is present. When all of these hold, `take_o` is high.
- R6: When `take_o` is high, `vec_o` is the lowest index among the enabled requests. When `take_o` is low, `vec_o` is 0.
- R7: A cycle with `take_o` high clears `gie_o` at the next edge. It also clears the event flag of the source on `vec_o`, unless a new event arrives on that source in the same cycle.
- R8: A cycle with `reti_i` high and `cli_i` low sets `gie_o` at the next edge. No accept happens in that cycle, so at least one more instruction boundary must pass before a pending request is taken.
- R9: A cycle with `sei_i` high and `cli_i` low sets `gie_o` at the next edge. Inside a handler this lets an enabled request preempt it at the next boundary.
- R10: `cli_i` blocks any accept in its own cycle, and `gie_o` is 0 after the next edge. This holds even when `sei_i` or `reti_i` is high in the same cycle.
- R11: `en_we_i` loads `en_data_i` into the per-source enables. Requests that are flagged but masked stay pending and are taken later, one per accept, in index order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Per-source request inputs (event strobe or level) |
| en_we_i | input | 1 | Write strobe for the per-source enable mask |
| en_data_i | input | N_SRC | New enable mask |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_data_i | input | N_SRC | Ones select flags to clear |
| retire_i | input | 1 | Core instruction boundary |
| reti_i | input | 1 | Return-from-handler retires this cycle |
| sei_i | input | 1 | Set global enable |
| cli_i | input | 1 | Clear global enable, effective at once |
| take_o | output | 1 | One-cycle accept strobe |
| vec_o | output | IDX_W | Index of the accepted source |
| gie_o | output | 1 | Global enable state |
| flags_o | output | N_SRC | Event flags (level bits read 0) |

## Verification
The hardest case to reach is a cycle where several conditions meet at one boundary. Examples are a pending request together with a return, or a clear of the global enable in the same cycle as a set or an arriving event. The nested case is also hard: it needs a handler to be entered, the global enable to be set inside it, and then a higher-priority event. The stimulus first drives directed sequences that build each of these situations step by step: it latches flags while masked, enters a handler, and then pulses the return or the disable together with `retire_i`. After that, a long random phase toggles all control pins densely, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    GC_KEEP  = 2'd0,
    GC_SET   = 2'd1,
    GC_CLEAR = 2'd2
  } gie_cmd_e;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int          N_SRC    = 8,
  parameter logic [N_SRC-1:0] LVL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_data_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] req_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LVL_MASK[i]) begin : g_level
      // level source: request follows the pin, no storage
      assign flags_o[i] = 1'b0;
      assign req_o[i]   = src_i[i];
    end else begin : g_event
      logic flag_q;
      logic drop;
      assign drop = (clr_we_i & clr_data_i[i]) | ack_i[i];
      always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (src_i[i]) flag_q <= 1'b1;
        else if (drop)     flag_q <= 1'b0;
      end
      assign flags_o[i] = flag_q;
      assign req_o[i]   = flag_q;

      // R3
      clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_data_i[i] && !src_i[i]) |=> !flags_o[i]);
      // R2
      event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_i[i] |=> flags_o[i]);
    end
  end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irqc_gie.sv
module irqc_gie
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic reti_i,
  input  logic sei_i,
  input  logic cli_i,
  output logic gie_o
);
  gie_cmd_e cmd;
  logic     gie_q;

  always_comb begin
    if (cli_i || take_i)      cmd = GC_CLEAR;
    else if (reti_i || sei_i) cmd = GC_SET;
    else                      cmd = GC_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gie_q <= 1'b0;
    else begin
      case (cmd)
        GC_SET:   gie_q <= 1'b1;
        GC_CLEAR: gie_q <= 1'b0;
        default:  gie_q <= gie_q;
      endcase
    end
  end
  assign gie_o = gie_q;

  // R10
  cli_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !gie_o);
  // R8
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !cli_i) |=> gie_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int               N_SRC    = 8,
  parameter logic [N_SRC-1:0] LVL_MASK = 8'b1100_0000,
  localparam int              IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             en_we_i,
  input  logic [N_SRC-1:0] en_data_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_data_i,
  input  logic             retire_i,
  input  logic             reti_i,
  input  logic             sei_i,
  input  logic             cli_i,
  output logic             take_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] raw_req;
  logic [N_SRC-1:0] live_req;
  logic [N_SRC-1:0] ack_mask;
  logic             any_req;
  logic [IDX_W-1:0] win_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= en_data_i;
  end

  irqc_flags #(.N_SRC(N_SRC), .LVL_MASK(LVL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .ack_i(ack_mask), .flags_o(flags_o), .req_o(raw_req)
  );

  assign live_req = raw_req & en_q;

  irqc_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i(live_req), .any_o(any_req), .idx_o(win_idx)
  );

  // boundary gate: no accept in a return cycle or under a same-cycle disable
  assign take_o   = retire_i & gie_o & ~cli_i & ~reti_i & any_req;
  assign vec_o    = take_o ? win_idx : '0;
  assign ack_mask = take_o ? (N_SRC'(1) << win_idx) : '0;

  irqc_gie u_gie (
    .clk(clk), .rst_n(rst_n), .take_i(take_o),
    .reti_i(reti_i), .sei_i(sei_i), .cli_i(cli_i), .gie_o(gie_o)
  );

  // R5
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (retire_i && gie_o && !cli_i && !reti_i));
  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (live_req[vec_o] &&
                ((live_req & ((N_SRC'(1) << vec_o) - N_SRC'(1))) == '0)));
  // R7
  entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o);
  // R4
  level_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & LVL_MASK) == '0);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int  CLK_PERIOD = 10;
  localparam int  N = 8;
  localparam logic [N-1:0] LVL = 8'b1100_0000;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0, en_d = '0, clr_d = '0;
  logic en_we = 0, clr_we = 0, retire = 0, reti = 0, sei = 0, cli = 0;
  logic take; logic [2:0] vec; logic gie; logic [N-1:0] flags;

  int checks = 0, errors = 0;
  logic [N-1:0] m_flags = '0, m_en = '0;
  logic m_gie = 0;
  logic obs_take; logic [2:0] obs_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .LVL_MASK(LVL)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .en_we_i(en_we), .en_data_i(en_d),
    .clr_we_i(clr_we), .clr_data_i(clr_d), .retire_i(retire), .reti_i(reti),
    .sei_i(sei), .cli_i(cli), .take_o(take), .vec_o(vec), .gie_o(gie),
    .flags_o(flags));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] m_live();
    return (m_flags | (src & LVL)) & m_en;
  endfunction

  function automatic int m_win();
    logic [N-1:0] l = m_live();
    for (int i = 0; i < N; i++) if (l[i]) return i;
    return -1;
  endfunction

  task automatic step(input logic [N-1:0] s, input logic rt, input logic rti,
                      input logic se, input logic cl);
    logic e_take; int w;
    @(negedge clk);
    src = s; retire = rt; reti = rti; sei = se; cl = cl; cli = cl;
    #1;
    w = m_win();
    e_take = rt && m_gie && !cl && !rti && (w >= 0);
    obs_take = take; obs_vec = vec;
    chk(take, e_take, "R5 take");
    chk(vec, e_take ? w : 0, "R6 vec");
    chk(gie, m_gie, "R8/R9/R10 gie");
    chk(flags, m_flags, "R2/R3 flags");
    @(posedge clk);
    if (clr_we) m_flags = m_flags & ~clr_d;
    if (e_take) m_flags[w] = 1'b0;
    m_flags = (m_flags | (s & ~LVL)) & ~LVL;
    if (en_we) m_en = en_d;
    if (cl || e_take) m_gie = 0;
    else if (rti || se) m_gie = 1;
    #1;
    en_we = 0; clr_we = 0;
  endtask

  task automatic idle(); step('0, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(flags, 0, "R1 flags"); chk(gie, 0, "R1 gie"); chk(take, 0, "R1 take");
    rst_n = 1;
    // R2: events latch while everything masked
    step(8'h0A, 1, 0, 0, 0);
    idle();
    chk(flags, 8'h0A, "R2 flags latched masked");
    // R3: clear bit 3, then a zero write
    clr_we = 1; clr_d = 8'h08; idle();
    chk(flags, 8'h02, "R3 clear by one");
    clr_we = 1; clr_d = 8'h00; idle();
    chk(flags, 8'h02, "R3 zero write no effect");
    clr_we = 1; clr_d = 8'h04; step(8'h04, 0, 0, 0, 0);
    chk(flags, 8'h06, "R3 event beats clear");
    clr_we = 1; clr_d = 8'h04; idle();
    // R11 enable all, R9 set gie, R5/R6 accept of source 1
    en_we = 1; en_d = 8'hFF; step('0, 0, 0, 1, 0);
    step('0, 1, 0, 0, 0);
    chk(obs_take, 1, "R5 take at boundary"); chk(obs_vec, 1, "R6 vec=1");
    chk(gie, 0, "R7 gie cleared"); chk(flags, 8'h00, "R7 flag cleared");
    // R4: level pulse while masked globally is lost
    step(8'h40, 1, 0, 0, 0);
    chk(obs_take, 0, "R4 no take while gie off");
    step('0, 0, 0, 1, 0);
    step('0, 1, 0, 0, 0);
    chk(obs_take, 0, "R4 level pulse lost");
    chk(flags, 8'h00, "R4 no level flag");
    // R8: return with pending event, no accept in that cycle
    step('0, 0, 0, 0, 1);
    step(8'h20, 0, 0, 0, 0);
    step('0, 1, 1, 0, 0);
    chk(obs_take, 0, "R8 no take on return");
    chk(gie, 1, "R8 gie set");
    step('0, 1, 0, 0, 0);
    chk(obs_take, 1, "R8 take after one instr"); chk(obs_vec, 5, "R8 vec=5");
    // R9 nesting: sei in handler, then higher event
    step('0, 1, 0, 1, 0);
    step(8'h01, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0);
    chk(obs_take, 1, "R9 nested take"); chk(obs_vec, 0, "R9 vec=0");
    // R10: cli with sei and event same boundary
    step('0, 0, 0, 1, 0);
    step(8'h80, 1, 0, 1, 1);
    chk(obs_take, 0, "R10 cli blocks"); chk(gie, 0, "R10 gie off");
    // R11: masked flags then serviced in order
    en_we = 1; en_d = 8'h00; step(8'h1C, 0, 0, 1, 0);
    en_we = 1; en_d = 8'hFF; idle();
    for (int k = 2; k <= 4; k++) begin
      step('0, 1, 0, 0, 0);
      chk(obs_vec, k, "R11 ordered service");
      step('0, 1, 1, 0, 0);
    end
    // random phase compared against the model every cycle
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] r = 8'($urandom);
      en_we = ($urandom % 16) == 0; en_d = 8'($urandom);
      clr_we = ($urandom % 8) == 0; clr_d = 8'($urandom);
      step(((r & 8'h3F) == 8'h01) ? 8'h01 : (8'($urandom) & 8'($urandom) & 8'($urandom)),
           ($urandom % 3) != 0, ($urandom % 7) == 0, ($urandom % 5) == 0,
           ($urandom % 11) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule